// File: doc/BRIEF.md
# BCD Calendar Real-Time Clock with Alarm

This peripheral keeps wall-clock time and date in packed BCD behind a plain 32-bit register bus (byte address, write enable, write data, registered read data). It stays frozen after reset until software writes a fixed 32-bit unlock word to the control register. Once unlocked, every pulse on the one-per-second tick input advances seconds, minutes and hours on a 24-hour clock. The day of month, month and two-digit year (00 to 99 meaning 2000 to 2099) follow the seconds, and a separate binary weekday counter steps at each midnight.

A programmable alarm time and alarm date are compared with the running clock after every advance. A full match sets a sticky status flag, and software clears it by writing 1. The interrupt output is that flag gated by an enable bit. Software may rewrite the time, date or weekday at any moment. A write that lands in the same cycle as a tick takes effect and the tick is dropped.

Top module: `bcal_rtc`

## Requirements
- R1: After reset the clock is inactive and ticks leave the time and date unchanged. Writing exactly 0xA5EB1357 to the control register (offset 0x00) sets its bit 0, which then stays set. Any other value written there leaves bit 0 at 0. Time, date and weekday registers can be written while inactive.
- R2: The time register (offset 0x0C) holds BCD seconds in bits 7:0, minutes in bits 15:8 and hours in bits 23:16. Each active tick adds one second. Seconds and minutes wrap 59 to 00 and hours wrap 23 to 00, each wrap carrying into the next field.
- R3: The date register (offset 0x10) holds BCD day in bits 7:0, month 01 to 12 in bits 15:8 and year 00 to 99 in bits 23:16. An hour wrap advances the day. A day past the month length wraps to 01 and advances the month. Month 12 wraps to 01 and advances the year, and year 99 wraps to 00.
- R4: April, June, September and November have 30 days. February has 29 days when the year is a multiple of 4 (00 included) and 28 days otherwise. All other months have 31 days. Bit 0 of the leap register (offset 0x24) reads 1 exactly when the current year is a multiple of 4.
- R5: The weekday register (offset 0x18, bits 2:0, binary 0 to 6) advances by one at each day rollover, wraps from 6 to 0, and is unchanged by ticks that do not cross midnight.
- R6: Bit 0 of the status register (offset 0x2C) is the alarm flag. It sets after a tick advance that leaves every time field equal to the alarm time register (offset 0x1C) and every date field equal to the alarm date register (offset 0x20). The alarm registers use the time and date layouts. The flag sets whatever the enable is, and a match on only part of the fields does not set it.
- R7: The interrupt output is the alarm flag ANDed with bit 0 of the enable register (offset 0x28), registered, so it follows one cycle later.
- R8: Writing 1 to status bit 0 clears the flag. Writing 0 leaves it unchanged.
- R9: A write to the time, date or weekday register in the same cycle as a tick loads the written value, and the tick is discarded.
- R10: Reset values are time 00:00:00, date day 01 month 01 year 00, weekday 0, with the flag, the enable and the interrupt all at 0. The format register (offset 0x14) reads bit 0 as 1 (24-hour mode) and ignores writes. Read data appears on the cycle after the address is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_1hz | input | 1 | One-cycle pulse per second |
| bus_addr | input | 6 | Byte address of the register |
| bus_we | input | 1 | Write enable |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| alarm_irq | output | 1 | Alarm interrupt, flag and enable |

## Verification
The bench targets the carry chain at its edges. These are second and minute wraps, the full midnight of 31 December 2099, the end of February in leap and common years, and the end of 30- and 31-day months. A wrong month table or leap test would land on an impossible date or skip a valid one. It also covers a near-miss alarm whose time matches but whose date differs, where a partial comparator would raise a false interrupt. It checks a status write of 0, which a plain-write register would wrongly clear. It checks a time write colliding with a tick, where a design that let the tick win would show the value one second late. Finally, it checks wrong unlock words and ticks before unlock, where a lax gate would let the clock run.

// File: rtl/bcal_rtc_pkg.sv
package bcal_rtc_pkg;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 6;
  localparam logic [DATA_W-1:0] UNLOCK_WORD = 32'hA5EB1357;

  localparam logic [ADDR_W-1:0] A_CTRL  = 6'h00;
  localparam logic [ADDR_W-1:0] A_TOD   = 6'h0C;
  localparam logic [ADDR_W-1:0] A_DATE  = 6'h10;
  localparam logic [ADDR_W-1:0] A_FMT   = 6'h14;
  localparam logic [ADDR_W-1:0] A_WDAY  = 6'h18;
  localparam logic [ADDR_W-1:0] A_ATOD  = 6'h1C;
  localparam logic [ADDR_W-1:0] A_ADATE = 6'h20;
  localparam logic [ADDR_W-1:0] A_LEAP  = 6'h24;
  localparam logic [ADDR_W-1:0] A_IEN   = 6'h28;
  localparam logic [ADDR_W-1:0] A_STAT  = 6'h2C;

  typedef struct packed {
    logic [7:0] hour;
    logic [7:0] minute;
    logic [7:0] second;
  } tod_t;

  typedef struct packed {
    logic [7:0] year;
    logic [7:0] month;
    logic [7:0] day;
  } date_t;

  // Next packed-BCD value; at or beyond 'last' the field restarts at 'first'.
  function automatic logic [7:0] bcd_step(input logic [7:0] v,
                                          input logic [7:0] last,
                                          input logic [7:0] first);
    if (v >= last) return first;
    if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'd0};
    return {v[7:4], v[3:0] + 4'd1};
  endfunction
endpackage

// File: rtl/bcal_month_len.sv
module bcal_month_len
  import bcal_rtc_pkg::*;
(
  input  date_t      cur,
  output logic [7:0] last_day,
  output logic       leap
);
  logic [6:0] year_bin;

  always_comb begin
    year_bin = {3'b000, cur.year[7:4]} * 7'd10 + {3'b000, cur.year[3:0]};
    leap     = (year_bin[1:0] == 2'b00);
    case (cur.month)
      8'h02:                      last_day = leap ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: last_day = 8'h30;
      default:                    last_day = 8'h31;
    endcase
  end
endmodule

// File: rtl/bcal_counter.sv
module bcal_counter
  import bcal_rtc_pkg::*;
#(
  parameter int                WDAY_W    = 3,
  parameter logic [WDAY_W-1:0] WDAY_LAST = 3'd6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              active,
  input  logic              tick,
  input  logic              ld_tod,
  input  logic              ld_date,
  input  logic              ld_wday,
  input  tod_t              wr_tod,
  input  date_t             wr_date,
  input  logic [WDAY_W-1:0] wr_wday,
  output tod_t              tod_q,
  output date_t             date_q,
  output logic [WDAY_W-1:0] wday_q,
  output logic              leap,
  output logic              adv_q
);
  logic [7:0] last_day;
  logic       load_any, step;
  logic       c_min, c_hour, c_day, c_mon, c_year;

  bcal_month_len len_i (.cur(date_q), .last_day(last_day), .leap(leap));

  always_comb begin
    load_any = ld_tod | ld_date | ld_wday;
    step     = tick & active & ~load_any;
    c_min    = (tod_q.second >= 8'h59);
    c_hour   = c_min  & (tod_q.minute >= 8'h59);
    c_day    = c_hour & (tod_q.hour >= 8'h23);
    c_mon    = c_day  & (date_q.day >= last_day);
    c_year   = c_mon  & (date_q.month >= 8'h12);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tod_q  <= '0;
      date_q <= '{year: 8'h00, month: 8'h01, day: 8'h01};
      wday_q <= '0;
      adv_q  <= 1'b0;
    end else begin
      adv_q <= step;
      if (load_any) begin
        if (ld_tod)  tod_q  <= wr_tod;
        if (ld_date) date_q <= wr_date;
        if (ld_wday) wday_q <= wr_wday;
      end else if (step) begin
        tod_q.second <= bcd_step(tod_q.second, 8'h59, 8'h00);
        if (c_min)  tod_q.minute <= bcd_step(tod_q.minute, 8'h59, 8'h00);
        if (c_hour) tod_q.hour   <= bcd_step(tod_q.hour, 8'h23, 8'h00);
        if (c_day) begin
          date_q.day <= bcd_step(date_q.day, last_day, 8'h01);
          wday_q     <= (wday_q >= WDAY_LAST) ? '0 : wday_q + 1'b1;
        end
        if (c_mon)  date_q.month <= bcd_step(date_q.month, 8'h12, 8'h01);
        if (c_year) date_q.year  <= bcd_step(date_q.year, 8'h99, 8'h00);
      end
    end
  end

  // R1
  idle_frozen_chk: assert property (@(posedge clk) disable iff (rst)
    (!active && !load_any) |=> ($stable(tod_q) && $stable(date_q)));
  // R2
  sec_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (step && tod_q.second == 8'h59) |=> (tod_q.second == 8'h00));
  // R5
  wday_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (step && c_day && wday_q == WDAY_LAST) |=> (wday_q == '0));
  // R9
  load_wins_chk: assert property (@(posedge clk) disable iff (rst)
    ld_tod |=> (tod_q == $past(wr_tod)));
endmodule

// File: rtl/bcal_alarm.sv
module bcal_alarm
  import bcal_rtc_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  adv,
  input  tod_t  tod,
  input  date_t date,
  input  logic  ld_atod,
  input  logic  ld_adate,
  input  tod_t  wr_tod,
  input  date_t wr_date,
  input  logic  clr,
  output tod_t  atod_q,
  output date_t adate_q,
  output logic  flag_q
);
  logic hit;

  always_comb hit = adv && (tod == atod_q) && (date == adate_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      atod_q  <= '0;
      adate_q <= '0;
      flag_q  <= 1'b0;
    end else begin
      if (ld_atod)  atod_q  <= wr_tod;
      if (ld_adate) adate_q <= wr_date;
      if (hit)      flag_q  <= 1'b1;
      else if (clr) flag_q  <= 1'b0;
    end
  end

  // R6
  match_sets_chk: assert property (@(posedge clk) disable iff (rst)
    (adv && tod == atod_q && date == adate_q) |=> flag_q);
  // R8
  w1c_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (clr && !adv && flag_q) |=> !flag_q);
  // R8
  flag_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!clr && flag_q) |=> flag_q);
endmodule

// File: rtl/bcal_rtc.sv
module bcal_rtc
  import bcal_rtc_pkg::*;
#(
  parameter int WDAY_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_1hz,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              alarm_irq
);
  logic              active_q, ien_q, flag, leap, adv;
  tod_t              tod, atod, wr_tod;
  date_t             date, adate, wr_date;
  logic [WDAY_W-1:0] wday;
  logic              wr_ctrl, wr_tod_en, wr_date_en, wr_wday_en;
  logic              wr_atod, wr_adate, wr_ien, wr_stat;

  always_comb begin
    wr_tod     = tod_t'(bus_wdata[23:0]);
    wr_date    = date_t'(bus_wdata[23:0]);
    wr_ctrl    = bus_we && bus_addr == A_CTRL;
    wr_tod_en  = bus_we && bus_addr == A_TOD;
    wr_date_en = bus_we && bus_addr == A_DATE;
    wr_wday_en = bus_we && bus_addr == A_WDAY;
    wr_atod    = bus_we && bus_addr == A_ATOD;
    wr_adate   = bus_we && bus_addr == A_ADATE;
    wr_ien     = bus_we && bus_addr == A_IEN;
    wr_stat    = bus_we && bus_addr == A_STAT;
  end

  bcal_counter #(.WDAY_W(WDAY_W), .WDAY_LAST(WDAY_W'(6))) cnt_i (
    .clk(clk), .rst(rst), .active(active_q), .tick(tick_1hz),
    .ld_tod(wr_tod_en), .ld_date(wr_date_en), .ld_wday(wr_wday_en),
    .wr_tod(wr_tod), .wr_date(wr_date), .wr_wday(bus_wdata[WDAY_W-1:0]),
    .tod_q(tod), .date_q(date), .wday_q(wday), .leap(leap), .adv_q(adv)
  );

  bcal_alarm alm_i (
    .clk(clk), .rst(rst), .adv(adv), .tod(tod), .date(date),
    .ld_atod(wr_atod), .ld_adate(wr_adate), .wr_tod(wr_tod), .wr_date(wr_date),
    .clr(wr_stat && bus_wdata[0]),
    .atod_q(atod), .adate_q(adate), .flag_q(flag)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      active_q  <= 1'b0;
      ien_q     <= 1'b0;
      alarm_irq <= 1'b0;
      bus_rdata <= '0;
    end else begin
      if (wr_ctrl && bus_wdata == UNLOCK_WORD) active_q <= 1'b1;
      if (wr_ien) ien_q <= bus_wdata[0];
      alarm_irq <= flag & ien_q;
      case (bus_addr)
        A_CTRL:  bus_rdata <= {{(DATA_W-1){1'b0}}, active_q};
        A_TOD:   bus_rdata <= {8'h00, tod};
        A_DATE:  bus_rdata <= {8'h00, date};
        A_FMT:   bus_rdata <= {{(DATA_W-1){1'b0}}, 1'b1};
        A_WDAY:  bus_rdata <= {{(DATA_W-WDAY_W){1'b0}}, wday};
        A_ATOD:  bus_rdata <= {8'h00, atod};
        A_ADATE: bus_rdata <= {8'h00, adate};
        A_LEAP:  bus_rdata <= {{(DATA_W-1){1'b0}}, leap};
        A_IEN:   bus_rdata <= {{(DATA_W-1){1'b0}}, ien_q};
        A_STAT:  bus_rdata <= {{(DATA_W-1){1'b0}}, flag};
        default: bus_rdata <= '0;
      endcase
    end
  end

  // R1
  active_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    active_q |=> active_q);
  // R7
  irq_needs_enable_chk: assert property (@(posedge clk) disable iff (rst)
    !ien_q |=> !alarm_irq);
endmodule

// File: tb/bcal_rtc_tb_top.sv
module bcal_rtc_tb_top;
  localparam time CLK_PERIOD = 10ns;
  localparam int  NVEC = 10;
  // {start time, start date, expected time, expected date} after one tick
  localparam logic [95:0] VEC [NVEC] = '{
    {24'h123456, 24'h230615, 24'h123457, 24'h230615},
    {24'h000059, 24'h230615, 24'h000100, 24'h230615},
    {24'h105959, 24'h230615, 24'h110000, 24'h230615},
    {24'h235959, 24'h991231, 24'h000000, 24'h000101},
    {24'h235959, 24'h230228, 24'h000000, 24'h230301},
    {24'h235959, 24'h240228, 24'h000000, 24'h240229},
    {24'h235959, 24'h240229, 24'h000000, 24'h240301},
    {24'h235959, 24'h210430, 24'h000000, 24'h210501},
    {24'h235959, 24'h210130, 24'h000000, 24'h210131},
    {24'h000959, 24'h001130, 24'h001000, 24'h001130}
  };

  logic        clk = 1'b0, rst = 1'b1, tick = 1'b0, we = 1'b0;
  logic [5:0]  addr = '0;
  logic [31:0] wdata = '0, rdata, rv;
  logic        irq;
  int          checks = 0, errors = 0;
  bit          done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bcal_rtc dut_i (.clk(clk), .rst(rst), .tick_1hz(tick), .bus_addr(addr),
    .bus_we(we), .bus_wdata(wdata), .bus_rdata(rdata), .alarm_irq(irq));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk); addr = a; wdata = d; we = 1'b1;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; we = 1'b0;
    @(posedge clk); #1 d = rdata;
  endtask

  task automatic pulse();
    @(negedge clk); tick = 1'b1;
    @(negedge clk); tick = 1'b0;
    @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    // R10 reset state
    rd(6'h00, rv); check("R10 ctrl", rv, 32'h0);
    rd(6'h0C, rv); check("R10 time", rv, 32'h0);
    rd(6'h10, rv); check("R10 date", rv, 32'h000101);
    rd(6'h18, rv); check("R10 wday", rv, 32'h0);
    rd(6'h2C, rv); check("R10 stat", rv, 32'h0);
    check("R10 irq", {31'h0, irq}, 32'h0);
    wr(6'h14, 32'h0);
    rd(6'h14, rv); check("R10 fmt", rv, 32'h1);
    // R1 inactive clock ignores ticks, wrong code rejected
    pulse();
    rd(6'h0C, rv); check("R1 tick while idle", rv, 32'h0);
    wr(6'h0C, 32'h010203);
    pulse();
    rd(6'h0C, rv); check("R1 write while idle", rv, 32'h010203);
    wr(6'h00, 32'h12345678);
    rd(6'h00, rv); check("R1 bad code", rv, 32'h0);
    wr(6'h00, 32'hA5EB1357);
    rd(6'h00, rv); check("R1 unlock", rv, 32'h1);
    wr(6'h00, 32'h0);
    rd(6'h00, rv); check("R1 sticky", rv, 32'h1);
    // R2 R3 R4 R5 vector table
    for (int i = 0; i < NVEC; i++) begin
      wr(6'h0C, {8'h0, VEC[i][95:72]});
      wr(6'h10, {8'h0, VEC[i][71:48]});
      wr(6'h18, 32'd6);
      pulse();
      rd(6'h0C, rv); check("R2 time step", rv, {8'h0, VEC[i][47:24]});
      rd(6'h10, rv); check("R3 R4 date step", rv, {8'h0, VEC[i][23:0]});
      rd(6'h18, rv);
      check("R5 weekday", rv, (VEC[i][7:0] != VEC[i][55:48]) ? 32'd0 : 32'd6);
    end
    // R4 leap register
    wr(6'h10, 32'h240101); rd(6'h24, rv); check("R4 leap 24", rv, 32'h1);
    wr(6'h10, 32'h230101); rd(6'h24, rv); check("R4 leap 23", rv, 32'h0);
    wr(6'h10, 32'h000101); rd(6'h24, rv); check("R4 leap 00", rv, 32'h1);
    // R5 weekday holds without midnight
    wr(6'h0C, 32'h100000); wr(6'h18, 32'd3); pulse();
    rd(6'h18, rv); check("R5 no rollover", rv, 32'd3);
    // R6 partial match: date differs
    wr(6'h0C, 32'h082958); wr(6'h10, 32'h240710);
    wr(6'h1C, 32'h082959); wr(6'h20, 32'h240711);
    pulse();
    rd(6'h2C, rv); check("R6 partial no flag", rv, 32'h0);
    // R6 full match, enable off
    wr(6'h0C, 32'h082958); wr(6'h20, 32'h240710);
    pulse();
    rd(6'h2C, rv); check("R6 full match", rv, 32'h1);
    check("R7 irq masked", {31'h0, irq}, 32'h0);
    // R7 enable
    wr(6'h28, 32'h1);
    rd(6'h2C, rv); check("R7 irq enabled", {31'h0, irq}, 32'h1);
    // R8 write 0 keeps, write 1 clears
    wr(6'h2C, 32'h0);
    rd(6'h2C, rv); check("R8 write0 keeps", rv, 32'h1);
    wr(6'h2C, 32'h1);
    rd(6'h2C, rv); check("R8 write1 clears", rv, 32'h0);
    check("R7 irq after clear", {31'h0, irq}, 32'h0);
    // R9 write collides with tick
    @(negedge clk); addr = 6'h0C; wdata = 32'h112233; we = 1'b1; tick = 1'b1;
    @(negedge clk); we = 1'b0; tick = 1'b0;
    rd(6'h0C, rv); check("R9 write wins", rv, 32'h112233);
    finish_run();
  end
endmodule